// File: doc/BRIEF.md
# Periodic Self-Refresh Window Controller

This block drives the self-refresh enable of a memory. It does not keep self-refresh on all the time. Instead it opens a short refresh window once per long, software-selected period and keeps self-refresh off for the rest of that period. Each period begins with an "open" event, which turns self-refresh on. A "close" event then follows a programmable window length later and turns it off. The window length is normally set to one native refresh interval of the memory, for example 64 ms. The period can be many seconds, for example 10 s.

Both lengths are counted in ticks. A prescaler inside the block makes one tick every `TICK_CYCLES` clocks. The default makes a 1 ms tick from a 50 MHz clock.

The period and window values are captured only at period boundaries, so a window never changes length while it is open. The first open event fires as soon as `run` is asserted. Dropping `run` shuts self-refresh off and clears all counters.

Top module: `srwin_ctrl`

## Requirements
- R1: After reset, with `run` low, `sr_en`, `open_pulse` and `close_pulse` are all 0.
- R2: On the first clock edge that samples `run` high after it was low, `open_pulse` and `sr_en` go high in the next cycle. This is the start of cycle 0 of the first period.
- R3: While `run` stays high, `open_pulse` is high for one cycle at the start of every period. A period lasts `period_ms*TICK_CYCLES` clocks. A `period_ms` of 0 is treated as 1.
- R4: Every cycle in which `open_pulse` is high also has `sr_en` high.
- R5: When the window is shorter than the period, `sr_en` stays high for exactly `window_ms*TICK_CYCLES` clocks from the start of the period. In the cycle where it falls, `close_pulse` is high for one cycle. A `window_ms` of 0 is treated as 1.
- R6: When the effective window is equal to or longer than the effective period, `sr_en` stays high without a break and `close_pulse` never fires.
- R7: A clock edge that samples `run` low forces `sr_en`, `open_pulse` and `close_pulse` low in the next cycle, with no close pulse. Asserting `run` again starts over from R2.
- R8: `period_ms` and `window_ms` are captured at the start of a period and hold for that whole period. A change made during a period takes effect at the next period start.
- R9: `open_pulse` and `close_pulse` never go high in the same cycle. `sr_en` only rises in a cycle that has `open_pulse` high, and only falls in a cycle that has `close_pulse` high or that follows a clock edge with `run` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables periodic operation; low forces self-refresh off |
| period_ms | input | PERIOD_W | Long refresh period in ticks (0 acts as 1) |
| window_ms | input | WIN_W | Self-refresh window length in ticks (0 acts as 1) |
| sr_en | output | 1 | Self-refresh enable level to the memory |
| open_pulse | output | 1 | One-cycle pulse at each window opening |
| close_pulse | output | 1 | One-cycle pulse at each window closing |

## Verification
The assertions assume that `run` is a plain level-sensitive input and that `period_ms` and `window_ms` may change in any cycle. No fixed relation between the period and window values is assumed, since the clamp handles every ordering.

The stimulus changes inputs only between clock edges, so each value is held steady across the edge that samples it. With a prescaler of a few clocks, it sweeps every effective period from 1 to 6 against every window from 1 to 7, including zero values. This covers windows shorter than, equal to, and longer than the period. Separate runs change the configuration in the middle of a period and drop `run` while a window is open.

// File: rtl/srwin_ctrl.sv
module srwin_ctrl #(
  parameter int TICK_CYCLES = 50000,
  parameter int PERIOD_W    = 16,
  parameter int WIN_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period_ms,
  input  logic [WIN_W-1:0]    window_ms,
  output logic                sr_en,
  output logic                open_pulse,
  output logic                close_pulse
);

  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int CW    = (PERIOD_W > WIN_W) ? PERIOD_W : WIN_W;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic                running;
  logic                clamp;
  logic [PRE_W-1:0]    pre_cnt;
  logic [PERIOD_W-1:0] per_cnt, per_end;
  logic [WIN_W-1:0]    win_cnt, win_end;

  wire [PERIOD_W-1:0] per_eff = (period_ms == '0) ? PERIOD_W'(1) : period_ms;
  wire [WIN_W-1:0]    win_eff = (window_ms == '0) ? WIN_W'(1) : window_ms;
  wire                clamp_in = CW'(win_eff) >= CW'(per_eff);

  wire tick     = running && (pre_cnt == PRE_LAST);
  wire start    = run && !running;
  wire boundary = tick && (per_cnt == per_end);
  wire win_hit  = tick && sr_en && !clamp && (win_cnt == win_end);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      running     <= 1'b0;
      sr_en       <= 1'b0;
      open_pulse  <= 1'b0;
      close_pulse <= 1'b0;
      clamp       <= 1'b0;
      pre_cnt     <= '0;
      per_cnt     <= '0;
      win_cnt     <= '0;
      per_end     <= '0;
      win_end     <= '0;
    end else begin
      open_pulse  <= start || boundary;
      close_pulse <= win_hit;
      if (running)
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (start || boundary) begin
        running <= 1'b1;
        sr_en   <= 1'b1;
        per_cnt <= '0;
        win_cnt <= '0;
        per_end <= per_eff - 1'b1;
        win_end <= win_eff - 1'b1;
        clamp   <= clamp_in;
      end else begin
        if (tick)
          per_cnt <= per_cnt + 1'b1;
        if (tick && sr_en)
          win_cnt <= win_cnt + 1'b1;
        if (win_hit)
          sr_en <= 1'b0;
      end
    end
  end

  a_r4_open_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    open_pulse |-> sr_en);

  a_r5_close_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    close_pulse |-> !sr_en);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_pulse && close_pulse));

  a_r9_rise_with_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_en) |-> open_pulse);

  a_r9_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_en) |-> (close_pulse || !$past(run)));

  a_r9_single_open: assert property (@(posedge clk) disable iff (!rst_n)
    (open_pulse && TICK_CYCLES > 1) |=> !open_pulse);

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sr_en && !open_pulse && !close_pulse));

  a_r6_clamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp && run && sr_en) |=> (sr_en || !$past(run)));

endmodule

// File: tb/srwin_ctrl_bench.sv
module srwin_ctrl_bench;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] period_ms = 8'd0;
  logic [7:0] window_ms = 8'd0;
  logic       sr_en, open_pulse, close_pulse;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  srwin_ctrl #(.TICK_CYCLES(T), .PERIOD_W(8), .WIN_W(8)) u_srwin_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .period_ms(period_ms),
    .window_ms(window_ms), .sr_en(sr_en), .open_pulse(open_pulse),
    .close_pulse(close_pulse)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Runs one configuration from a fresh start. After cycle chg_at the inputs
  // switch to (np, nw), which the model applies from the next period (R8).
  // If stop_at >= 0, run drops at that cycle (R7).
  task automatic run_case(input int p, input int w, input int len,
                          input int chg_at, input int np, input int nw,
                          input int stop_at);
    int mc, mp, mw;
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    period_ms = 8'(p);
    window_ms = 8'(w);
    run = 1'b1;
    mc = 0; mp = eff(p); mw = eff(w);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (stop_at >= 0 && c > stop_at) begin
        check("R7 sr_en", sr_en, 1'b0);
        check("R7 open_pulse", open_pulse, 1'b0);
        check("R7 close_pulse", close_pulse, 1'b0);
      end else begin
        check((c == 0) ? "R2 open_pulse" : "R3 open_pulse", open_pulse, mc == 0);
        check((mw >= mp) ? "R6 close_pulse" : "R5 close_pulse", close_pulse,
              (mw < mp) && (mc == mw * T));
        check((mw >= mp) ? "R6 sr_en" : "R4 R5 sr_en", sr_en,
              (mw >= mp) || (mc < mw * T));
      end
      if (c == chg_at) begin
        period_ms = 8'(np);
        window_ms = 8'(nw);
      end
      if (stop_at >= 0 && c == stop_at) run = 1'b0;
      mc = mc + 1;
      if (mc == mp * T) begin
        mc = 0;
        mp = eff(int'(period_ms));
        mw = eff(int'(window_ms));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sr_en", sr_en, 1'b0);
    check("R1 open_pulse", open_pulse, 1'b0);
    check("R1 close_pulse", close_pulse, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sr_en idle", sr_en, 1'b0);
    check("R1 open idle", open_pulse, 1'b0);

    for (int p = 0; p <= 6; p++)
      for (int w = 0; w <= 7; w++)
        run_case(p, w, 2 * eff(p) * T + 3, -1, p, w, -1);

    // R8: mid-period change applies at the next boundary, both directions
    run_case(3, 2, 60, 1, 5, 4, -1);
    run_case(5, 4, 60, 6, 2, 1, -1);
    run_case(4, 1, 60, 3, 2, 3, -1);
    run_case(2, 5, 60, 2, 6, 1, -1);

    // R7: drop run while a window is open, then restart cleanly
    run_case(6, 5, 40, -1, 6, 5, 7);
    run_case(3, 2, 30, -1, 3, 2, -1);
    run_case(4, 9, 30, -1, 4, 9, 2);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule